// File: doc/BRIEF.md
# Interrupt Source Aggregator

This block gathers up to eight level-driven interrupt lines coming from on-chip functions and reduces them to one host interrupt. Each line owns one bit of a byte-wide status register. A bit tracks its line: when the line rises the bit sets, and when the line falls the bit clears. A byte-wide enable register gates each status bit. The host interrupt is raised whenever at least one bit is set in both registers.

A host reaches the block through a simple byte port. There is a write strobe, an address and write data, and read data is decoded combinationally from the address. The host can read and write the status, the enable and a plain stored routing byte. It can also read a fixed two-byte revision identifier. The host may overwrite the status byte at any time. That written value holds until the next edge on a source line. Line bit 0 is the flash-storage function, bit 1 the memory card, bit 2 the USB host, bit 3 the serial port and bit 4 the display. Bits 5 to 7 are spare.

Top module: `irq_gather`

## Requirements
- R1: After reset the status, enable and routing bytes read 0x00 and `irq_o` is low.
- R2: A rising edge on source line i sets status bit i, and a falling edge clears it. The new value is seen one clock after the edge is presented. A line that holds its level leaves its bit unchanged.
- R3: `irq_o` is registered. It equals the OR over all bits of (status AND enable) as they stand after the same clock edge.
- R4: A host write to offset 0x50 replaces the status byte. It affects only the bits whose source line does not change level in that cycle.
- R5: When a source line changes level in the same cycle as a host status write, the line level wins for that bit.
- R6: Offset 0x52 holds the enable byte and offset 0x54 holds the routing byte. Both are read/write. The routing byte has no effect on `irq_o`.
- R7: Offset 0x08 reads 0x03 and offset 0x09 reads 0x00. Writes to these two offsets have no effect.
- R8: Any other offset reads 0x00. A write to such an offset leaves the status, enable and routing bytes unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| src_i | input | 8 | Level interrupt lines from the functions |
| we_i | input | 1 | Host write strobe |
| addr_i | input | 8 | Host byte offset |
| wdata_i | input | 8 | Host write data |
| rdata_o | output | 8 | Host read data for `addr_i` (combinational) |
| irq_o | output | 1 | Host interrupt |

## Verification
Source edges, host writes and the interrupt all take effect at the first rising clock edge after they are presented. Read data follows the address with no delay. The bench drives every input on the falling edge. It then waits for one rising edge and samples `irq_o` and the read-back on the next falling edge, so each result is checked exactly one clock after its stimulus. A fixed-seed random run mixes line changes with host writes, including writes to status in the same cycle as line edges. A bench model built from the requirements predicts every byte.

// File: rtl/irq_gather.sv
module irq_gather #(
  parameter int DW       = 8,
  parameter int AW       = 8,
  parameter int REV_CODE = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] src_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          irq_o
);
  localparam logic [AW-1:0] OFS_REV_LO = AW'(8'h08);
  localparam logic [AW-1:0] OFS_REV_HI = AW'(8'h09);
  localparam logic [AW-1:0] OFS_STAT   = AW'(8'h50);
  localparam logic [AW-1:0] OFS_ENAB   = AW'(8'h52);
  localparam logic [AW-1:0] OFS_ROUTE  = AW'(8'h54);

  logic [DW-1:0] src_q, stat_q, enab_q, route_q;
  logic [DW-1:0] edge_w, stat_d, enab_d;
  logic          wr_stat, wr_enab, wr_route;

  assign wr_stat  = we_i && addr_i == OFS_STAT;
  assign wr_enab  = we_i && addr_i == OFS_ENAB;
  assign wr_route = we_i && addr_i == OFS_ROUTE;

  assign edge_w = src_i ^ src_q;
  assign stat_d = (edge_w & src_i) | (~edge_w & (wr_stat ? wdata_i : stat_q));
  assign enab_d = wr_enab ? wdata_i : enab_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q   <= '0;
      stat_q  <= '0;
      enab_q  <= '0;
      route_q <= '0;
      irq_o   <= 1'b0;
    end else begin
      src_q   <= src_i;
      stat_q  <= stat_d;
      enab_q  <= enab_d;
      if (wr_route) route_q <= wdata_i;
      irq_o   <= |(stat_d & enab_d);
    end
  end

  always_comb begin
    case (addr_i)
      OFS_REV_LO: rdata_o = DW'(REV_CODE);
      OFS_REV_HI: rdata_o = '0;
      OFS_STAT:   rdata_o = stat_q;
      OFS_ENAB:   rdata_o = enab_q;
      OFS_ROUTE:  rdata_o = route_q;
      default:    rdata_o = '0;
    endcase
  end

  assert_line_edge_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_i != src_q) |=> ((stat_q & $past(edge_w)) == ($past(src_i) & $past(edge_w))));

  assert_host_write_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_stat && src_i == src_q) |=> (stat_q == $past(wdata_i)));

  assert_irq_cause_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> ((stat_q & enab_q) != '0));

  assert_unmapped_write_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !wr_stat && !wr_enab && !wr_route) |=> ($stable(enab_q) && $stable(route_q)));

  assert_rev_read_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == OFS_REV_LO) |-> (rdata_o == DW'(REV_CODE)));
endmodule

// File: tb/test_irq_gather.sv
module test_irq_gather;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] src = '0, addr = '0, wdata = '0, rdata;
  logic       we = 1'b0, irq;
  int n_chk = 0, n_bad = 0;
  logic [7:0] m_src = '0, m_stat = '0, m_enab = '0, m_route = '0;

  always #5 clk = ~clk;

  irq_gather i_irq_gather (.clk_i(clk), .rst_ni(rst_n), .src_i(src), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq));

  function automatic logic exp_irq(input logic [7:0] s, input logic [7:0] e);
    return |(s & e);
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    we = 1'b0; addr = a; #1; d = rdata;
  endtask

  task automatic cycle(input logic [7:0] s, input logic w, input logic [7:0] a,
                       input logic [7:0] d);
    logic [7:0] chg;
    src = s; we = w; addr = a; wdata = d;
    chg = s ^ m_src;
    m_stat = (chg & s) | (~chg & ((w && a == 8'h50) ? d : m_stat));
    if (w && a == 8'h52) m_enab = d;
    if (w && a == 8'h54) m_route = d;
    m_src = s;
    @(posedge clk); @(negedge clk);
    we = 1'b0;
  endtask

  task automatic check_all(input string req);
    logic [7:0] v;
    chk(req, {7'd0, irq}, {7'd0, exp_irq(m_stat, m_enab)});
    rd(8'h50, v); chk(req, v, m_stat);
    rd(8'h52, v); chk(req, v, m_enab);
    rd(8'h54, v); chk(req, v, m_route);
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] v;
    void'($urandom(32'd1234));
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    check_all("R1");
    // R2 rising and falling edges
    cycle(8'h05, 1'b0, 8'h00, 8'h00); check_all("R2 rise");
    cycle(8'h04, 1'b0, 8'h00, 8'h00); check_all("R2 fall");
    rd(8'h50, v); chk("R2", v, 8'h04);
    // R3 enable gating and one-clock latency
    cycle(8'h04, 1'b1, 8'h52, 8'h04); check_all("R3");
    chk("R3", {7'd0, irq}, 8'h01);
    cycle(8'h00, 1'b0, 8'h00, 8'h00); check_all("R3 drop");
    chk("R3", {7'd0, irq}, 8'h00);
    // R4 host overwrite
    cycle(8'h00, 1'b1, 8'h50, 8'hA4); check_all("R4");
    chk("R4", {7'd0, irq}, 8'h01);
    // R5 same-cycle edge beats write
    cycle(8'h81, 1'b1, 8'h50, 8'h00); check_all("R5");
    rd(8'h50, v); chk("R5", v, 8'h81);
    // R6 routing stored, no effect on irq
    cycle(8'h81, 1'b1, 8'h52, 8'h00);
    cycle(8'h81, 1'b1, 8'h54, 8'hFF); check_all("R6");
    chk("R6", {7'd0, irq}, 8'h00);
    // R7 revision bytes, read-only
    cycle(8'h81, 1'b1, 8'h08, 8'h55); cycle(8'h81, 1'b1, 8'h09, 8'h66);
    rd(8'h08, v); chk("R7", v, 8'h03);
    rd(8'h09, v); chk("R7", v, 8'h00);
    check_all("R7");
    // R8 unmapped offsets
    cycle(8'h81, 1'b1, 8'h51, 8'hFF); check_all("R8");
    rd(8'h51, v); chk("R8", v, 8'h00);
    rd(8'hFF, v); chk("R8", v, 8'h00);
    // random mix covering R2..R6, R8
    for (int k = 0; k < 400; k++) begin
      logic [7:0] a;
      int sel;
      sel = $urandom % 5;
      a = (sel == 0) ? 8'h50 : (sel == 1) ? 8'h52 : (sel == 2) ? 8'h54 :
          (sel == 3) ? 8'h08 : 8'($urandom);
      cycle(($urandom % 2) ? 8'($urandom) : m_src, 1'($urandom), a, 8'($urandom));
      check_all("R2-random");
    end
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule